// File: doc/BRIEF.md
# Seven-Channel High/Low Phase PWM Generator

This block produces seven independent pulse-width-modulated outputs. Six of them leave the block as pin outputs. The seventh is for internal use. Each channel describes its waveform with two lengths, both counted in ticks of a selectable source: how long the output stays high, and how long it then stays low. A period is the sum of the two lengths. Each length runs from 1 to 65536 ticks, so a period lies between 2 and 131072 ticks.

Software programs the block through a flat register port with one write and one read per cycle. Each channel is controlled by:
- a 3-bit source selector, which picks one of eight tick-enable inputs;
- a bypass bit, which routes the selected source straight to the output;
- three gates that are enabled in turn. The pre-divider gate runs the counters. The post-divider gate passes the divided waveform. The output gate drives the channel output.

New lengths are taken up only at the start of a period. The source selector is locked while the channel's counters run.

Top module: `wh_pwm_bank`

## Requirements
- R1: After reset every register reads as zero and every output is low.
- R2: Take a channel with all three gates open, bypass clear and its selected source ticking every cycle. Its output is high for W cycles, then low for H cycles, and this repeats. W and H are the values at addresses 8+2n and 9+2n. A stored 0 acts as 1.
- R3: A channel's counters advance only on cycles in which its selected source input is high. The selector is the field at bits 3n+2 to 3n of address 0, and value s picks src_tick[s]. If the selected source never ticks, the output stays at its current level.
- R4: With the bypass bit (bit 24+n of address 0) set and all gates open, the output equals the selected source input in the same cycle. W and H are ignored.
- R5: New W or H values written during a period take effect only from the next period's high phase. The current period completes with its old lengths.
- R6: Clearing the output gate (address 3, bit n) or the post-divider gate (address 2, bit n) forces the channel output low.
- R7: Clearing the pre-divider gate (address 1, bit n) drives the output low and resets the counters. When the gate is set again, the waveform restarts at the beginning of a high phase.
- R8: A write to address 0 leaves channel n's source field unchanged while that channel's pre-divider gate is set.
- R9: Registers read back what was written. The length registers are 17 bits wide and hold values up to 65536.
- R10: Channels run independently. External channel 5 and the internal channel 6 can run different W and H at the same time without affecting each other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Write address |
| wr_data | input | 32 | Write data |
| rd_addr | input | 5 | Read address |
| rd_data | output | 32 | Read data for rd_addr, combinational |
| src_tick | input | 8 | Source tick enables that channels can select |
| pwm_pin | output | 6 | External channel outputs 0 to 5 |
| pwm_int | output | 1 | Internal channel 6 output |

## Verification
The divider is exercised with several kinds of stimulus, and each one separates a different kind of fault:
- A steady source with unequal lengths separates the high count from the low count.
- A length change in the middle of a period shows whether the new values are buffered until the period boundary.
- A gate-off then gate-on sequence shows whether the counters reset to the start of a high phase.
- Selecting a source that never ticks shows whether the counters advance only on ticks.
- A toggling source in bypass shows whether the stored lengths are truly ignored.
- Running two channels at once with different lengths exposes any sharing of state between channels.

// File: rtl/wh_pwm_pkg.sv
package wh_pwm_pkg;
  localparam int SEL_W    = 3;
  localparam int BYP_BASE = 24;
  localparam int LEN_BASE = 8;

  // A programmed length of zero is treated as a single tick.
  function automatic logic [16:0] eff_len(input logic [16:0] v);
    return (v == '0) ? 17'd1 : v;
  endfunction

  // True when the tick now being counted is the last one of a phase.
  function automatic logic phase_last(input logic [16:0] cnt, input logic [16:0] len);
    return ({1'b0, cnt} + 18'd1) >= {1'b0, eff_len(len)};
  endfunction

  function automatic int wait_addr(input int ch);
    return LEN_BASE + 2 * ch;
  endfunction

  function automatic int hold_addr(input int ch);
    return LEN_BASE + 2 * ch + 1;
  endfunction
endpackage

// File: rtl/wh_pwm_regs.sv
module wh_pwm_regs
  import wh_pwm_pkg::*;
#(
  parameter int NCH    = 7,
  parameter int CNT_W  = 17,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   wr_en,
  input  logic [ADDR_W-1:0]      wr_addr,
  input  logic [DATA_W-1:0]      wr_data,
  input  logic [ADDR_W-1:0]      rd_addr,
  output logic [DATA_W-1:0]      rd_data,
  output logic [NCH*SEL_W-1:0]   sel_q,
  output logic [NCH-1:0]         byp_q,
  output logic [NCH-1:0]         pre_q,
  output logic [NCH-1:0]         post_q,
  output logic [NCH-1:0]         oe_q,
  output logic [NCH*CNT_W-1:0]   wait_q,
  output logic [NCH*CNT_W-1:0]   hold_q
);
  localparam logic [ADDR_W-1:0] A_SEL  = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_PRE  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_POST = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_OE   = ADDR_W'(3);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q  <= '0;
      byp_q  <= '0;
      pre_q  <= '0;
      post_q <= '0;
      oe_q   <= '0;
      wait_q <= '0;
      hold_q <= '0;
    end else if (wr_en) begin
      if (wr_addr == A_SEL) begin
        for (int n = 0; n < NCH; n++) begin
          // source field is locked while the channel counters run
          if (!pre_q[n]) sel_q[n*SEL_W +: SEL_W] <= wr_data[n*SEL_W +: SEL_W];
        end
        byp_q <= wr_data[BYP_BASE +: NCH];
      end
      if (wr_addr == A_PRE)  pre_q  <= wr_data[NCH-1:0];
      if (wr_addr == A_POST) post_q <= wr_data[NCH-1:0];
      if (wr_addr == A_OE)   oe_q   <= wr_data[NCH-1:0];
      for (int n = 0; n < NCH; n++) begin
        if (wr_addr == ADDR_W'(wait_addr(n))) wait_q[n*CNT_W +: CNT_W] <= wr_data[CNT_W-1:0];
        if (wr_addr == ADDR_W'(hold_addr(n))) hold_q[n*CNT_W +: CNT_W] <= wr_data[CNT_W-1:0];
      end
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == A_SEL) begin
      rd_data[NCH*SEL_W-1:0]         = sel_q;
      rd_data[BYP_BASE +: NCH]       = byp_q;
    end
    if (rd_addr == A_PRE)  rd_data[NCH-1:0] = pre_q;
    if (rd_addr == A_POST) rd_data[NCH-1:0] = post_q;
    if (rd_addr == A_OE)   rd_data[NCH-1:0] = oe_q;
    for (int n = 0; n < NCH; n++) begin
      if (rd_addr == ADDR_W'(wait_addr(n))) rd_data[CNT_W-1:0] = wait_q[n*CNT_W +: CNT_W];
      if (rd_addr == ADDR_W'(hold_addr(n))) rd_data[CNT_W-1:0] = hold_q[n*CNT_W +: CNT_W];
    end
  end
endmodule

// File: rtl/wh_pwm_chan.sv
module wh_pwm_chan
  import wh_pwm_pkg::*;
#(
  parameter int CNT_W = 17,
  parameter int NSRC  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [NSRC-1:0]  src_tick,
  input  logic [SEL_W-1:0] sel,
  input  logic             pre_en,
  input  logic             post_en,
  input  logic             out_en,
  input  logic             bypass,
  input  logic [CNT_W-1:0] wait_len,
  input  logic [CNT_W-1:0] hold_len,
  output logic             tick,
  output logic             phase_hi,
  output logic             pwm
);
  logic [CNT_W-1:0] cnt, sh_wait, sh_hold;
  logic             div_wave;

  assign tick = src_tick[sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt      <= '0;
      phase_hi <= 1'b1;
      sh_wait  <= CNT_W'(1);
      sh_hold  <= CNT_W'(1);
    end else if (!pre_en) begin
      // frozen and reset; pick up the current lengths for the next start
      cnt      <= '0;
      phase_hi <= 1'b1;
      sh_wait  <= wait_len;
      sh_hold  <= hold_len;
    end else if (tick) begin
      if (phase_hi) begin
        if (phase_last(cnt, sh_wait)) begin
          phase_hi <= 1'b0;
          cnt      <= '0;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end else begin
        if (phase_last(cnt, sh_hold)) begin
          phase_hi <= 1'b1;
          cnt      <= '0;
          sh_wait  <= wait_len;
          sh_hold  <= hold_len;
        end else begin
          cnt <= cnt + CNT_W'(1);
        end
      end
    end
  end

  assign div_wave = bypass ? tick : phase_hi;
  assign pwm      = out_en & post_en & pre_en & div_wave;
endmodule

// File: rtl/wh_pwm_bank.sv
module wh_pwm_bank
  import wh_pwm_pkg::*;
#(
  parameter int NCH    = 7,
  parameter int CNT_W  = 17,
  parameter int NSRC   = 8,
  parameter int ADDR_W = 5,
  parameter int DATA_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [DATA_W-1:0] rd_data,
  input  logic [NSRC-1:0]   src_tick,
  output logic [NCH-2:0]    pwm_pin,
  output logic              pwm_int
);
  localparam int NEXT = NCH - 1;

  logic [NCH*SEL_W-1:0] sel_q;
  logic [NCH-1:0]       byp_q, pre_q, post_q, oe_q;
  logic [NCH*CNT_W-1:0] wait_q, hold_q;
  logic [NCH-1:0]       chan_tick, phase_hi, chan_pwm;

  wh_pwm_regs #(.NCH(NCH), .CNT_W(CNT_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .sel_q(sel_q), .byp_q(byp_q),
    .pre_q(pre_q), .post_q(post_q), .oe_q(oe_q), .wait_q(wait_q), .hold_q(hold_q)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_chan
    wh_pwm_chan #(.CNT_W(CNT_W), .NSRC(NSRC)) u_chan (
      .clk(clk), .rst_n(rst_n), .src_tick(src_tick),
      .sel(sel_q[n*SEL_W +: SEL_W]),
      .pre_en(pre_q[n]), .post_en(post_q[n]), .out_en(oe_q[n]), .bypass(byp_q[n]),
      .wait_len(wait_q[n*CNT_W +: CNT_W]), .hold_len(hold_q[n*CNT_W +: CNT_W]),
      .tick(chan_tick[n]), .phase_hi(phase_hi[n]), .pwm(chan_pwm[n])
    );
  end

  assign pwm_pin = chan_pwm[NEXT-1:0];
  assign pwm_int = chan_pwm[NCH-1];
endmodule

// File: rtl/wh_pwm_bank_chk.sv
module wh_pwm_bank_chk
  import wh_pwm_pkg::*;
#(
  parameter int NCH = 7
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic [NCH*SEL_W-1:0] sel_q,
  input logic [NCH-1:0]       byp_q,
  input logic [NCH-1:0]       pre_q,
  input logic [NCH-1:0]       post_q,
  input logic [NCH-1:0]       oe_q,
  input logic [NCH-1:0]       chan_tick,
  input logic [NCH-1:0]       phase_hi,
  input logic [NCH-1:0]       chan_pwm
);
  for (genvar n = 0; n < NCH; n++) begin : g_chk
    assert_gate_low_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (!oe_q[n] || !post_q[n]) |-> !chan_pwm[n]);
    assert_restart_high_R7: assert property (@(posedge clk) disable iff (!rst_n)
      !pre_q[n] |=> phase_hi[n]);
    assert_no_tick_stall_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_q[n] && !chan_tick[n]) |=> $stable(phase_hi[n]));
    assert_sel_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
      pre_q[n] |=> $stable(sel_q[n*SEL_W +: SEL_W]));
    assert_bypass_follow_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (byp_q[n] && pre_q[n] && post_q[n] && oe_q[n]) |-> (chan_pwm[n] == chan_tick[n]));
  end
endmodule

bind wh_pwm_bank wh_pwm_bank_chk #(.NCH(NCH)) u_chk (.*);

// File: tb/wh_pwm_bank_bench.sv
module wh_pwm_bank_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [4:0]  wr_addr = '0;
  logic [31:0] wr_data = '0;
  logic [4:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic [7:0]  src_tick;
  logic [5:0]  pwm_pin;
  logic        pwm_int;
  logic        tog = 1'b0;
  logic [6:0]  outs;
  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct { logic [6:0] exp; logic [6:0] msk; string tag; } exp_t;
  exp_t sb_q[$];

  always #2.5 clk = ~clk;
  always @(posedge clk) tog <= ~tog;
  assign src_tick = {5'b0, 1'b0, tog, 1'b1};
  assign outs = {pwm_int, pwm_pin};

  wh_pwm_bank u_wh_pwm_bank (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .src_tick(src_tick),
    .pwm_pin(pwm_pin), .pwm_int(pwm_int)
  );

  // monitor: one expected item per cycle
  always @(negedge clk) begin
    if (sb_q.size() > 0) begin
      exp_t e;
      e = sb_q.pop_front();
      checks++;
      if ((outs & e.msk) !== (e.exp & e.msk)) begin
        errors++;
        $display("FAIL %s: outputs=%b expected=%b (mask %b)", e.tag, outs, e.exp, e.msk);
      end
    end
  end

  function automatic bit wave_bit(int k, int w, int h);
    return (k % (w + h)) < w;
  endfunction

  task automatic push_wave(int ca, int wa, int ha, int cb, int wb, int hb, int n, string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.exp = '0; e.msk = '0; e.tag = tag;
      e.msk[ca] = 1'b1; e.exp[ca] = wave_bit(k, wa, ha);
      if (cb >= 0) begin
        e.msk[cb] = 1'b1; e.exp[cb] = wave_bit(k, wb, hb);
      end
      sb_q.push_back(e);
    end
  endtask

  task automatic push_const(int ch, bit v, int n, string tag);
    for (int k = 0; k < n; k++) begin
      exp_t e;
      e.exp = '0; e.msk = '0; e.tag = tag;
      e.msk[ch] = 1'b1; e.exp[ch] = v;
      sb_q.push_back(e);
    end
  endtask

  task automatic drain();
    while (sb_q.size() != 0) @(posedge clk);
  endtask

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    wr_en = 1'b1; wr_addr = 5'(a); wr_data = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic check_val(string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic rd_chk(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    rd_addr = 5'(a);
    #1 check_val(tag, rd_data, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R1: reset state
    @(negedge clk);
    check_val("R1 outputs", {25'b0, outs}, 32'h0);
    rd_chk(0, 32'h0, "R1 select");
    rd_chk(1, 32'h0, "R1 pre");
    rd_chk(2, 32'h0, "R1 post");
    rd_chk(3, 32'h0, "R1 oe");
    rd_chk(8, 32'h0, "R1 wait0");

    // R9: readback, including a full 17-bit length
    wr(8, 3); wr(9, 2); wr(20, 65536);
    rd_chk(8, 3, "R9 wait0");
    rd_chk(9, 2, "R9 hold0");
    rd_chk(20, 65536, "R9 wait6");

    // R2: basic wave on channel 0
    wr(3, 1); wr(2, 1); wr(1, 1);
    push_wave(0, 3, 2, -1, 0, 0, 15, "R2");
    drain();

    // R7: pre gate clear drives low, re-enable restarts at high
    wr(1, 0);
    push_const(0, 1'b0, 3, "R7");
    drain();
    // R5: lengths changed mid-period apply at next boundary
    wr(1, 1);
    push_wave(0, 3, 2, -1, 0, 0, 5, "R7 restart R5 old period");
    push_wave(0, 1, 4, -1, 0, 0, 10, "R5 new lengths");
    wr(8, 1); wr(9, 4);
    drain();

    // R8: source field locked while running
    wr(0, 32'h2);
    rd_chk(0, 32'h0, "R8 locked field");

    // R6: output and post gates
    wr(3, 0);
    push_const(0, 1'b0, 6, "R6 oe clear");
    drain();
    wr(3, 1); wr(2, 0);
    push_const(0, 1'b0, 6, "R6 post clear");
    drain();
    wr(2, 1);

    // R3: select a source that never ticks -> output stays high
    wr(1, 0); wr(0, 32'h2);
    rd_chk(0, 32'h2, "R3 select written");
    wr(1, 1);
    push_const(0, 1'b1, 20, "R3 no ticks");
    drain();

    // R4: bypass follows source 1 directly
    wr(1, 0); wr(0, 32'h0100_0001); wr(1, 1);
    for (int k = 0; k < 10; k++) begin
      @(negedge clk);
      check_val("R4 bypass", {31'b0, pwm_pin[0]}, {31'b0, src_tick[1]});
    end
    wr(1, 0); wr(0, 32'h0);

    // R10: channels 5 and 6 together
    wr(18, 2); wr(19, 3); wr(20, 4); wr(21, 1);
    wr(3, 32'h61); wr(2, 32'h61); wr(1, 32'h60);
    push_wave(5, 2, 3, 6, 4, 1, 20, "R10");
    drain();
    check_val("R10 ch0 idle", {31'b0, pwm_pin[0]}, 32'h0);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule